// File: doc/BRIEF.md
# Bus Read Requester with Address Latch and Open-Ended Wait

This block starts reads on a simple synchronous bus. A read request comes in on a valid/ready handshake and carries an address. On the cycle after the handshake, the block drives the address onto the bus. In that same single cycle it raises an address-latch strobe. After that it watches the target's wait line on every rising clock edge. While the wait line is high the block keeps waiting, and there is no limit on how long. On the first edge where the wait line is low, the block captures the data bus and goes back to idle.

The read result leaves on a one-cycle valid strobe together with the captured word. The result side has no back-pressure: the consumer must take the word in the strobe cycle. The result register keeps that word until the next capture.

The request side follows valid/ready rules:
- A request is accepted only on an edge where both `req_valid` and `req_ready` are high.
- `req_ready` is high only while no transfer is running.
- A requester that holds `req_valid` high while `req_ready` is low is simply not served. The block does not store the request.
- The strobe cycle is already idle, so a new request can be accepted in that same cycle and transfers can follow each other without a gap.

Top module: `bus_rd_requester`

## Requirements
- R1: During and right after reset, `bus_ale` is 0, `bus_addr` is 0, `rd_valid` is 0, `rd_data` is 0 and `req_ready` is 1.
- R2: After an edge on which `req_valid` and `req_ready` are both 1, the next cycle has `bus_ale` = 1 and `bus_addr` equal to the accepted `req_addr`. This lasts exactly one cycle. In every other cycle `bus_ale` is 0 and `bus_addr` is 0.
- R3: `req_ready` is 0 from the address cycle until the transfer's capture edge. It is 1 again in the cycle where `rd_valid` is high.
- R4: A request presented while `req_ready` is 0 is not accepted. No address cycle follows it.
- R5: From the edge that ends the address cycle onwards, `bus_wait` is sampled on every edge. Each edge with `bus_wait` = 1 keeps the block waiting with no capture, and any number of such edges may occur.
- R6: On the first sampled edge with `bus_wait` = 0, `bus_data` is captured. In the next cycle `rd_valid` is 1 for exactly one cycle and `rd_data` equals the captured value.
- R7: With zero wait cycles, `rd_valid` rises two cycles after the cycle in which `bus_ale` is high.
- R8: `rd_data` holds its value between strobes. Changes on `bus_data` outside the capture edge have no effect on it.
- R9: `bus_wait` and `bus_data` are ignored during the idle and address cycles. A low `bus_wait` in the address cycle causes no capture.
- R10: Transfers repeat without limit. A request accepted in the strobe cycle starts its address cycle on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block can accept a request (idle) |
| req_addr | input | ADDR_W | Address of the requested read |
| bus_ale | output | 1 | Address-latch strobe, one cycle per transfer |
| bus_addr | output | ADDR_W | Address on the bus during the strobe cycle, zero otherwise |
| bus_wait | input | 1 | Target not ready; data valid on the first edge it is low |
| bus_data | input | DATA_W | Read data bus from the target |
| rd_valid | output | 1 | One-cycle strobe for a captured word |
| rd_data | output | DATA_W | Last captured word |

## Verification
Some internal faults show up on the bus pins:
- If the phase register gets out of step, the next request may produce no address strobe, or `req_ready` may come back early. Either is visible within one cycle of the request or of the first wait edge.

Other faults show up on the result side:
- A capture taken at the wrong edge, or a missed capture, appears at the result strobe one cycle later. It shows as a wrong word, a strobe during a long wait, or a missing strobe.
- Decoy values on the wait and data lines during the address and idle cycles catch early sampling.
- A stale or changing result register is visible on `rd_data` in the idle cycles after a strobe.

// File: rtl/bus_rd_pkg.sv
package bus_rd_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_WAIT = 2'd2
  } phase_e;

endpackage

// File: rtl/brq_sequencer.sv
module brq_sequencer
  import bus_rd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   accept,
  input  logic   bus_wait,
  output phase_e phase,
  output logic   capture
);

  phase_e phase_q;
  phase_e phase_d;

  // the wait line only matters in the wait phase
  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (accept) phase_d = PH_ADDR;
      PH_ADDR: phase_d = PH_WAIT;
      PH_WAIT: if (!bus_wait) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign phase   = phase_q;
  assign capture = (phase_q == PH_WAIT) && !bus_wait;

endmodule

// File: rtl/brq_addr_stage.sv
module brq_addr_stage #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              ale,
  output logic [ADDR_W-1:0] addr_out
);

  logic              ale_q;
  logic [ADDR_W-1:0] addr_q;

  // the strobe and the address appear together for a single cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ale_q  <= 1'b0;
      addr_q <= '0;
    end else if (load) begin
      ale_q  <= 1'b1;
      addr_q <= addr_in;
    end else begin
      ale_q  <= 1'b0;
      addr_q <= '0;
    end
  end

  assign ale      = ale_q;
  assign addr_out = addr_q;

endmodule

// File: rtl/brq_capture.sv
module brq_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] data_in,
  output logic              valid,
  output logic [DATA_W-1:0] data_out
);

  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= capture;
      if (capture) data_q <= data_in;
    end
  end

  assign valid    = valid_q;
  assign data_out = data_q;

endmodule

// File: rtl/bus_rd_requester.sv
module bus_rd_requester
  import bus_rd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              bus_ale,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wait,
  input  logic [DATA_W-1:0] bus_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  phase_e phase;
  logic   capture;
  logic   accept;

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;

  brq_sequencer u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .bus_wait (bus_wait),
    .phase    (phase),
    .capture  (capture)
  );

  brq_addr_stage #(.ADDR_W(ADDR_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .addr_in  (req_addr),
    .ale      (bus_ale),
    .addr_out (bus_addr)
  );

  brq_capture #(.DATA_W(DATA_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (capture),
    .data_in  (bus_data),
    .valid    (rd_valid),
    .data_out (rd_data)
  );

endmodule

// File: rtl/bus_rd_requester_chk.sv
module bus_rd_requester_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              bus_ale,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wait,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data
);

  a_r2_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |=> !bus_ale);

  a_r2_addr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ale |-> (bus_addr == '0));

  a_r2_ale_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> bus_ale);

  a_r4_no_unaccepted_ale: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> $past(req_valid && req_ready));

  a_r3_busy_in_addr: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> !req_ready);

  a_r3_ready_at_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> req_ready);

  a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  a_r5_strobe_after_low_wait: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!bus_wait && !req_ready));

  a_r8_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable(rd_data));

endmodule

bind bus_rd_requester bus_rd_requester_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .bus_ale   (bus_ale),
  .bus_addr  (bus_addr),
  .bus_wait  (bus_wait),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data)
);

// File: tb/bus_rd_requester_test.sv
module bus_rd_requester_test;

  localparam int AW = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_addr;
  logic          bus_ale;
  logic [AW-1:0] bus_addr;
  logic          bus_wait;
  logic [DW-1:0] bus_data;
  logic          rd_valid;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [DW-1:0] sb_q[$];

  always #2 clk = ~clk;

  bus_rd_requester #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .bus_ale(bus_ale), .bus_addr(bus_addr),
    .bus_wait(bus_wait), .bus_data(bus_data), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: every result strobe must match the oldest expected word
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (sb_q.size() == 0) chk(1'b0, "R6 unexpected strobe", 64'(rd_data), 64'hx);
      else begin
        logic [DW-1:0] e;
        e = sb_q.pop_front();
        chk(rd_data == e, "R6 captured word", 64'(rd_data), 64'(e));
      end
    end
  end

  // called at a negedge in an idle cycle; returns at the negedge after the gap
  task automatic xfer(input logic [AW-1:0] a, input int nw, input logic [DW-1:0] d, input int gap);
    req_valid = 1'b1; req_addr = a;
    bus_wait = 1'b0; bus_data = ~d;                  // R9 decoy while idle
    chk(req_ready == 1'b1, "R3 ready when idle", 64'(req_ready), 64'd1);
    @(negedge clk);
    chk(bus_ale == 1'b1, "R2 ale in address cycle", 64'(bus_ale), 64'd1);
    chk(bus_addr == a, "R2 address on bus", 64'(bus_addr), 64'(a));
    chk(req_ready == 1'b0, "R3 busy in address cycle", 64'(req_ready), 64'd0);
    req_addr = ~a;                                   // R4 stray request while busy
    bus_wait = 1'b0; bus_data = d ^ 8'h5A;           // R9 decoy in address cycle
    sb_q.push_back(d);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < nw; i++) begin
      bus_wait = 1'b1; bus_data = DW'(i * 37 + 11);
      chk(bus_ale == 1'b0 && bus_addr == '0, "R4 no ale for stray request", 64'(bus_ale), 64'd0);
      chk(rd_valid == 1'b0, "R5 no strobe while waiting", 64'(rd_valid), 64'd0);
      chk(req_ready == 1'b0, "R3 busy while waiting", 64'(req_ready), 64'd0);
      @(negedge clk);
    end
    bus_wait = 1'b0; bus_data = d;
    chk(bus_ale == 1'b0, "R2 ale single cycle", 64'(bus_ale), 64'd0);
    @(negedge clk);
    bus_wait = 1'b1; bus_data = ~d;
    chk(rd_valid == 1'b1, (nw == 0) ? "R7 strobe with zero waits" : "R6 strobe after wait low",
        64'(rd_valid), 64'd1);
    chk(req_ready == 1'b1, "R3 ready in strobe cycle", 64'(req_ready), 64'd1);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      bus_data = DW'(g + 3);
      chk(rd_valid == 1'b0, "R6 strobe one cycle", 64'(rd_valid), 64'd0);
      chk(rd_data == d, "R8 result held", 64'(rd_data), 64'(d));
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 64'd0, 64'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; bus_wait = 1'b1; bus_data = '0;
    repeat (3) @(negedge clk);
    chk(bus_ale == 1'b0 && bus_addr == '0, "R1 bus quiet in reset", 64'(bus_ale), 64'd0);
    chk(rd_valid == 1'b0 && rd_data == '0, "R1 result clear in reset", 64'(rd_data), 64'd0);
    chk(req_ready == 1'b1, "R1 ready in reset", 64'(req_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_ale == 1'b0 && rd_valid == 1'b0, "R1 quiet after reset", 64'(bus_ale), 64'd0);
    // R9: low wait and busy data while idle produce no strobe
    bus_wait = 1'b0; bus_data = 8'hEE;
    repeat (3) @(negedge clk);
    chk(rd_valid == 1'b0 && rd_data == '0, "R9 idle inputs ignored", 64'(rd_data), 64'd0);
    xfer(16'h1234, 0,   8'hA5, 2);   // R7 zero waits
    xfer(16'h0001, 1,   8'h3C, 1);
    xfer(16'hBEEF, 5,   8'h00, 3);
    xfer(16'hFFFF, 300, 8'hFF, 1);   // R5 long wait
    xfer(16'h4000, 2,   8'h81, 0);   // R10 back-to-back
    xfer(16'h4001, 0,   8'h7E, 0);
    xfer(16'h4002, 3,   8'h19, 2);
    repeat (2) @(negedge clk);
    chk(sb_q.size() == 0, "R10 all transfers returned", 64'(sb_q.size()), 64'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule